// File: doc/BRIEF.md
# Accumulator ALU with Condition-Code Register

This block carries out the arithmetic, logic, shift and adjust operations of a small accumulator machine with 8-bit data. It also computes the five condition flags that go with each result. The datapath is combinational. An operation code, a left operand and a right operand produce a result and a proposed next flag set in the same cycle. A five-bit flag register holds the current flags. It loads the proposed set on every clock edge where `exec` is high and keeps its value at all other times.

Most operations read only the low bytes of the operands. The double-width add, subtract and compare read the full 16 bits. Sign extend and multiply produce a 16-bit result. Every other operation returns its byte in `res[7:0]` with zeros above it.

Each operation has its own rule for each flag: the flag is computed from the result, forced to a constant, or copied from the register unchanged. The half-carry flag is only defined after an add, so every other operation keeps it.

Flag vectors are ordered `{H,N,Z,V,C}`: H is bit 4, N is bit 3, Z is bit 2, V is bit 1 and C is bit 0.

Operation codes:
- 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare
- 5 AND, 6 OR, 7 XOR, 8 bit test, 9 pass, 10 test
- 11 clear, 12 complement, 13 negate, 14 increment, 15 decrement
- 16 shift left, 17 arithmetic shift right, 18 logical shift right, 19 rotate left, 20 rotate right
- 21 decimal adjust, 22 sign extend, 23 multiply
- 24 add16, 25 sub16, 26 cmp16

Top module: `cc_alu`

## Requirements
- R1: Add (0) and add with carry (1) return the 8-bit sum of lhs[7:0], rhs[7:0] and the carry-in, where the carry-in is C for op 1 and 0 for op 0. H is the carry out of bit 3 and C is the carry out of bit 7. V is set on two's-complement overflow. N is result bit 7 and Z is set when the result is zero.
- R2: Subtract (2), subtract with borrow (3, borrow-in = C) and compare (4) return lhs minus rhs minus the borrow-in. C is set when rhs plus the borrow-in exceeds lhs as unsigned values. V is set on signed overflow, N and Z follow the result, and H is held. Negate (13) returns 0 minus lhs, sets C when lhs is nonzero, sets V when lhs is 0x80, and holds H.
- R3: AND (5), OR (6), XOR (7), bit test (8, returns lhs AND rhs), pass (9, returns rhs) and test (10, returns lhs) update N and Z, clear V, and hold C and H.
- R4: Clear (11) returns 0 and forces N=0, Z=1, V=0 and C=0, holding H.
- R5: Complement (12) returns the bitwise inverse of lhs, updates N and Z, clears V and forces C=1.
- R6: Increment (14) and decrement (15) update N and Z. V is set for the 0x7F and 0x80 inputs respectively. C and H are held.
- R7: Shift left (16) moves lhs bit 7 into C, sets V to N XOR C of the result, and updates N and Z. Arithmetic shift right (17) keeps bit 7, moves bit 0 into C, updates N and Z, and holds V.
- R8: Logical shift right (18) and rotate right (20) force N=0, update Z, load C from lhs bit 0, and hold V. Rotate right moves the old C into bit 7.
- R9: Rotate left (19) moves the old C into bit 0 and lhs bit 7 into C, sets V to N XOR C, and updates N and Z.
- R10: Decimal adjust (21) adds 0x06 when H is set or the low digit exceeds 9. It adds 0x60 when C is set or lhs exceeds 0x99, and then sets C. Otherwise it keeps C. N and Z follow the result and V is cleared.
- R11: Sign extend (22) returns lhs[7:0] with bit 7 copied into the high byte. N is bit 15, Z is set when all 16 bits are zero, and V is cleared.
- R12: Multiply (23) returns the unsigned 16-bit product of the low bytes. Z is set when the whole product is zero, C is product bit 7, and N, V and H are held.
- R13: Add16 (24), sub16 (25) and cmp16 (26) work on all 16 bits. N is bit 15 and Z is set on a zero 16-bit result. V is set on signed overflow and C is the carry or borrow. H is held.
- R14: Reset clears the flag register to 0. The register changes only on an edge with exec high. Unused codes 27 to 31 return 0 and hold all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Load the proposed flags into the flag register on this edge |
| op | input | 5 | Operation code |
| lhs | input | 16 | Left operand (the accumulator) |
| rhs | input | 16 | Right operand (the memory value) |
| res | output | 16 | Result |
| flags_nx | output | 5 | Proposed next flags {H,N,Z,V,C} |
| flags | output | 5 | Current flag register {H,N,Z,V,C} |

## Verification
The only internal state is the flag register. A wrong held or forced bit shows on `flags` one edge after the `exec` that wrote it. It also shows at once on `res` and `flags_nx` for any following operation that reads C or H, such as add with carry, the rotates and decimal adjust. The bench keeps its own copy of the flags, runs random operations one after another, and compares both the combinational outputs and the register after every step. A lost or corrupted flag is therefore caught no later than the next operation.

// File: rtl/cc_alu.sv
module cc_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec,
  input  logic [4:0]  op,
  input  logic [15:0] lhs,
  input  logic [15:0] rhs,
  output logic [15:0] res,
  output logic [4:0]  flags_nx,
  output logic [4:0]  flags
);
  localparam logic [4:0] ADD = 5'd0,  ADC = 5'd1,  SUB = 5'd2,  SBC = 5'd3,  CMP = 5'd4;
  localparam logic [4:0] LAND = 5'd5, LOR = 5'd6,  LXOR = 5'd7, BTST = 5'd8, PASS = 5'd9;
  localparam logic [4:0] TST = 5'd10, CLR = 5'd11, COM = 5'd12, NEG = 5'd13, INC = 5'd14;
  localparam logic [4:0] DEC = 5'd15, SHL = 5'd16, ASR = 5'd17, LSR = 5'd18, ROL = 5'd19;
  localparam logic [4:0] ROR = 5'd20, DAA = 5'd21, SEX = 5'd22, MUL = 5'd23;
  localparam logic [4:0] ADD16 = 5'd24, SUB16 = 5'd25, CMP16 = 5'd26;

  logic [7:0] a, b;
  logic       c_in, h_in;
  assign a = lhs[7:0];
  assign b = rhs[7:0];
  assign c_in = flags[0];
  assign h_in = flags[4];

  logic       ci, bi;
  logic [8:0] sum9, dif9;
  logic [4:0] nib;
  logic [16:0] sum17, dif17;
  assign ci    = (op == ADC) & c_in;
  assign bi    = (op == SBC) & c_in;
  assign sum9  = {1'b0, a} + {1'b0, b} + {8'd0, ci};
  assign nib   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci};
  assign dif9  = {1'b0, a} - {1'b0, b} - {8'd0, bi};
  assign sum17 = {1'b0, lhs} + {1'b0, rhs};
  assign dif17 = {1'b0, lhs} - {1'b0, rhs};

  logic lo_fix, hi_fix;
  logic [7:0] daa_r;
  assign lo_fix = h_in | (a[3:0] > 4'd9);
  assign hi_fix = c_in | (a[7:4] > 4'd9) | ((a[7:4] > 4'd8) & (a[3:0] > 4'd9));
  assign daa_r  = a + {1'b0, hi_fix, hi_fix, 2'b00, lo_fix, lo_fix, 1'b0};

  logic [15:0] prod;
  assign prod = {8'd0, a} * {8'd0, b};

  logic [15:0] r;
  logic h, n, z, v, c, nz8;

  always_comb begin
    r = 16'd0;
    {h, n, z, v, c} = flags;
    nz8 = 1'b1;
    case (op)
      ADD, ADC: begin
        r[7:0] = sum9[7:0];
        h = nib[4];
        c = sum9[8];
        v = (a[7] == b[7]) & (sum9[7] != a[7]);
      end
      SUB, SBC, CMP: begin
        r[7:0] = dif9[7:0];
        c = dif9[8];
        v = (a[7] != b[7]) & (dif9[7] != a[7]);
      end
      NEG: begin
        r[7:0] = 8'd0 - a;
        c = |a;
        v = (a == 8'h80);
      end
      LAND, BTST: begin r[7:0] = a & b; v = 1'b0; end
      LOR:        begin r[7:0] = a | b; v = 1'b0; end
      LXOR:       begin r[7:0] = a ^ b; v = 1'b0; end
      PASS:       begin r[7:0] = b;     v = 1'b0; end
      TST:        begin r[7:0] = a;     v = 1'b0; end
      CLR: begin
        v = 1'b0;
        c = 1'b0;
      end
      COM: begin
        r[7:0] = ~a;
        v = 1'b0;
        c = 1'b1;
      end
      INC: begin r[7:0] = a + 8'd1; v = (a == 8'h7f); end
      DEC: begin r[7:0] = a - 8'd1; v = (a == 8'h80); end
      SHL: begin
        r[7:0] = {a[6:0], 1'b0};
        c = a[7];
        v = a[6] ^ a[7];
      end
      ASR: begin r[7:0] = {a[7], a[7:1]}; c = a[0]; end
      LSR: begin r[7:0] = {1'b0, a[7:1]}; c = a[0]; end
      ROL: begin
        r[7:0] = {a[6:0], c_in};
        c = a[7];
        v = a[6] ^ a[7];
      end
      ROR: begin r[7:0] = {c_in, a[7:1]}; c = a[0]; end
      DAA: begin
        r[7:0] = daa_r;
        c = c_in | hi_fix;
        v = 1'b0;
      end
      SEX: begin
        nz8 = 1'b0;
        r = {{8{a[7]}}, a};
        n = r[15];
        z = (r == 16'd0);
        v = 1'b0;
      end
      MUL: begin
        nz8 = 1'b0;
        r = prod;
        z = (prod == 16'd0);
        c = prod[7];
      end
      ADD16: begin
        nz8 = 1'b0;
        r = sum17[15:0];
        n = r[15];
        z = (r == 16'd0);
        c = sum17[16];
        v = (lhs[15] == rhs[15]) & (r[15] != lhs[15]);
      end
      SUB16, CMP16: begin
        nz8 = 1'b0;
        r = dif17[15:0];
        n = r[15];
        z = (r == 16'd0);
        c = dif17[16];
        v = (lhs[15] != rhs[15]) & (r[15] != lhs[15]);
      end
      default: nz8 = 1'b0;
    endcase
    if (nz8) begin
      n = r[7];
      z = (r[7:0] == 8'd0);
    end
    if (op == LSR || op == ROR) n = 1'b0;
  end

  assign res = r;
  assign flags_nx = {h, n, z, v, c};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= 5'd0;
    else if (exec) flags <= flags_nx;

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(flags));
  assert_clear_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == CLR |=> flags[3:0] == 4'b0100 && flags[4] == $past(flags[4]));
  assert_com_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == COM |=> flags[0] && !flags[1]);
  assert_rshift_n_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == LSR || op == ROR) |=> !flags[3] && flags[1] == $past(flags[1]));
  assert_logic_keep_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op >= LAND && op <= TST |=> !flags[1] && flags[0] == $past(flags[0]));
  assert_mul_carry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == MUL |=> flags[0] == $past(res[7]) && flags[3] == $past(flags[3]));
  assert_sub_hold_h_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec && (op == SUB || op == SBC || op == CMP || op == NEG) |=> flags[4] == $past(flags[4]));
endmodule

// File: tb/test_cc_alu.sv
`timescale 1ns/1ps
module test_cc_alu;
  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0;
  logic [4:0] op = 5'd0;
  logic [15:0] lhs = 16'd0, rhs = 16'd0;
  logic [15:0] res;
  logic [4:0] flags_nx, flags;
  int checks = 0, errors = 0;
  logic [4:0] mf = 5'd0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cc_alu i_cc_alu (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .lhs(lhs), .rhs(rhs),
                   .res(res), .flags_nx(flags_nx), .flags(flags));

  function automatic string req_of(input logic [4:0] o);
    case (o)
      0, 1: return "R1";
      2, 3, 4, 13: return "R2";
      5, 6, 7, 8, 9, 10: return "R3";
      11: return "R4";
      12: return "R5";
      14, 15: return "R6";
      16, 17: return "R7";
      18, 20: return "R8";
      19: return "R9";
      21: return "R10";
      22: return "R11";
      23: return "R12";
      24, 25, 26: return "R13";
      default: return "R14";
    endcase
  endfunction

  function automatic int sx8(input int x);
    return x > 127 ? x - 256 : x;
  endfunction
  function automatic int sx16(input int x);
    return x > 32767 ? x - 65536 : x;
  endfunction

  function automatic logic [20:0] model(input logic [4:0] o, input logic [15:0] l, input logic [15:0] r,
                                        input logic [4:0] f);
    int ai, bi, t, s, li, ri;
    logic [15:0] q;
    logic H, N, Z, V, C, nz;
    ai = int'(l[7:0]); bi = int'(r[7:0]); li = int'(l); ri = int'(r);
    {H, N, Z, V, C} = f;
    q = 16'd0; nz = 1'b1;
    case (o)
      0, 1: begin
        t = ai + bi + ((o == 1) ? int'(f[0]) : 0);
        s = sx8(ai) + sx8(bi) + ((o == 1) ? int'(f[0]) : 0);
        q = 16'(t % 256); C = t > 255; V = (s > 127) || (s < -128);
        H = ((ai % 16) + (bi % 16) + ((o == 1) ? int'(f[0]) : 0)) > 15;
      end
      2, 3, 4: begin
        t = ai - bi - ((o == 3) ? int'(f[0]) : 0);
        s = sx8(ai) - sx8(bi) - ((o == 3) ? int'(f[0]) : 0);
        q = 16'((t + 256) % 256); C = t < 0; V = (s > 127) || (s < -128);
      end
      13: begin q = 16'((256 - ai) % 256); C = ai != 0; V = ai == 128; end
      5, 8: begin q = {8'd0, l[7:0] & r[7:0]}; V = 0; end
      6: begin q = {8'd0, l[7:0] | r[7:0]}; V = 0; end
      7: begin q = {8'd0, l[7:0] ^ r[7:0]}; V = 0; end
      9: begin q = {8'd0, r[7:0]}; V = 0; end
      10: begin q = {8'd0, l[7:0]}; V = 0; end
      11: begin q = 0; V = 0; C = 0; end
      12: begin q = 16'(255 - ai); V = 0; C = 1; end
      14: begin q = 16'((ai + 1) % 256); V = ai == 127; end
      15: begin q = 16'((ai + 255) % 256); V = ai == 128; end
      16: begin q = 16'((ai * 2) % 256); C = ai >= 128; V = q[7] ^ C; end
      17: begin q = 16'(ai / 2 + (ai >= 128 ? 128 : 0)); C = ai % 2 == 1; end
      18: begin q = 16'(ai / 2); C = ai % 2 == 1; end
      19: begin q = 16'((ai * 2) % 256 + int'(f[0])); C = ai >= 128; V = q[7] ^ C; end
      20: begin q = 16'(ai / 2 + 128 * int'(f[0])); C = ai % 2 == 1; end
      21: begin
        t = ai;
        if (f[4] || (ai % 16) > 9) t += 6;
        if (f[0] || ai > 153) begin t += 96; C = 1; end
        q = 16'(t % 256); V = 0;
      end
      22: begin nz = 0; q = 16'(ai >= 128 ? ai + 65280 : ai); N = q[15]; Z = q == 0; V = 0; end
      23: begin nz = 0; q = 16'(ai * bi); Z = q == 0; C = q[7]; end
      24: begin
        nz = 0; t = li + ri; s = sx16(li) + sx16(ri);
        q = 16'(t % 65536); C = t > 65535; V = (s > 32767) || (s < -32768);
        N = q[15]; Z = q == 0;
      end
      25, 26: begin
        nz = 0; t = li - ri; s = sx16(li) - sx16(ri);
        q = 16'((t + 65536) % 65536); C = t < 0; V = (s > 32767) || (s < -32768);
        N = q[15]; Z = q == 0;
      end
      default: nz = 0;
    endcase
    if (nz) begin
      N = (o == 18 || o == 20) ? 1'b0 : q[7];
      Z = q[7:0] == 0;
    end
    return {q, H, N, Z, V, C};
  endfunction

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [15:0] l, input logic [15:0] r, input bit ex);
    logic [20:0] e;
    @(negedge clk);
    op = o; lhs = l; rhs = r; exec = ex;
    #1;
    e = model(o, l, r, mf);
    chk(req_of(o), "res", res, e[20:5]);
    chk(req_of(o), "flags_nx", {11'd0, flags_nx}, {11'd0, e[4:0]});
    @(posedge clk);
    #1;
    if (ex) mf = e[4:0];
    chk(ex ? req_of(o) : "R14", "flags", {11'd0, flags}, {11'd0, mf});
    exec = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_c0de);
    #12 chk("R14", "reset flags", {11'd0, flags}, 16'd0);
    rst_n = 1'b1;
    step(0, 16'h0008, 16'h0008, 1);
    step(1, 16'h007f, 16'h0000, 1);
    step(12, 16'h0000, 16'h0000, 1);
    step(1, 16'h00ff, 16'h0000, 1);
    step(2, 16'h0010, 16'h0011, 1);
    step(3, 16'h0080, 16'h0000, 1);
    step(13, 16'h0080, 16'h0000, 1);
    step(13, 16'h0000, 16'h0000, 1);
    step(11, 16'h0055, 16'h0000, 1);
    step(6, 16'h0000, 16'h0080, 1);
    step(12, 16'h0000, 16'h0000, 1);
    step(5, 16'h00f0, 16'h000f, 1);
    step(14, 16'h007f, 16'h0000, 1);
    step(15, 16'h0080, 16'h0000, 1);
    step(16, 16'h0040, 16'h0000, 1);
    step(17, 16'h0081, 16'h0000, 1);
    step(18, 16'h0001, 16'h0000, 1);
    step(20, 16'h00fe, 16'h0000, 1);
    step(19, 16'h0080, 16'h0000, 1);
    step(0, 16'h0019, 16'h0028, 1);
    step(21, 16'h0041, 16'h0000, 1);
    step(0, 16'h0099, 16'h0001, 1);
    step(21, 16'h009a, 16'h0000, 1);
    step(22, 16'h0080, 16'h0000, 1);
    step(22, 16'h0000, 16'h0000, 1);
    step(23, 16'h00ff, 16'h00ff, 1);
    step(23, 16'h0000, 16'h0012, 1);
    step(24, 16'h7fff, 16'h0001, 1);
    step(25, 16'h0000, 16'h0001, 1);
    step(26, 16'h8000, 16'h8000, 1);
    step(27, 16'h1234, 16'h5678, 1);
    step(12, 16'h0000, 16'h0000, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 31));
      step(o, 16'($urandom), 16'($urandom), ($urandom % 8) != 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule